// File: doc/BRIEF.md
# Read-Modify-Write Sequencer

This block changes one word of an external dual-port synchronous RAM in place. A request brings a word address and a 16-bit mask. The sequencer puts the address in one register that drives the address inputs of both RAM ports. Port B sees only the low bits of that address. The sequencer then takes the word that port A returns and XORs it with the mask. It holds the result in a write-data register and writes it back through port A at the same address. In the last state it drops write enable, pulses `done` and samples a group of general inputs into registers that have no part in the memory path. It also keeps the word that port B returned during the modify step, so that the two ports can be compared.

The RAM has a one-cycle registered read. The request port is valid/ready. `req_valid` must stay high, with `req_addr` and `req_mask` stable, until the first rising edge at which `req_ready` is also high. The request is taken at that edge. `req_ready` is high only when the sequencer is idle or in its final state, so a waiting request starts the next operation without a gap. The parameter `SETTLE` adds one wait state between the address load and the modify step. This gives the address a full extra clock period before the port B data is taken.

Top module: `rmw_sequencer`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `ram_we`, `done`, `ram_addr_a`, `ram_wdata`, `io_sampled` and `portb_capture` are all zero, and `req_ready` is 1.
- R2: `req_ready` is high only in the idle state and in the final (done) state. A request taken at an edge puts `req_addr` on `ram_addr_a` in the cycle that follows.
- R3: `ram_addr_a` does not change from the cycle after a request is taken up to and including that operation's done cycle.
- R4: In the done cycle, `ram_we` is 1 and `ram_wdata` equals the port A word stored at the address XOR the request mask. `ram_we` is 1 in no other cycle.
- R5: `ram_addr_b` always equals the low `BAW` bits of `ram_addr_a`.
- R6: With `SETTLE`=0, `done` is high for exactly one cycle: the third cycle after the edge that took the request. There is one done pulse per request taken.
- R7: At the edge that ends a done cycle, `io_sampled` takes the value of `io_in`. At every other edge it keeps its value.
- R8: At the end of an operation, `portb_capture` holds the word stored at RAM address {0, low `BAW` bits of the address}.
- R9: A request taken in a done cycle starts its load cycle at once. A following operation on the same address reads the word that the previous operation wrote.
- R10: With `SETTLE`=1, each operation takes one more cycle, so `done` falls in the fourth cycle after the request edge. The data results are the same as with `SETTLE`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by the sequencer and both RAM ports |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken at this edge |
| req_addr | input | AW | Word address to update |
| req_mask | input | DW | XOR mask applied to the word |
| io_in | input | IOW | General inputs to sample |
| ram_addr_a | output | AW | Port A address (registered) |
| ram_addr_b | output | BAW | Port B address, low slice of the same register |
| ram_we | output | 1 | Port A write enable |
| ram_wdata | output | DW | Port A write data (registered) |
| ram_rdata_a | input | DW | Port A read data |
| ram_rdata_b | input | DW | Port B read data |
| done | output | 1 | One-cycle pulse in the final state |
| io_sampled | output | IOW | Registered copy of `io_in` |
| portb_capture | output | DW | Port B word taken in the modify step |

## Verification
The bench runs two copies of the sequencer, one without the wait state and one with it, each against its own behavioural RAM. A reference model predicts every output on every cycle. Single requests separated by idle gaps check the latency of each variant and show whether write enable comes at the right time. Masks of all zeros, all ones and mixed bits separate a correct XOR from a pass-through or an inversion. Back-to-back requests to one address with its high bits set show whether the next read sees the previous write and whether port B uses the address slice. A burst of pseudo-random addresses, sent while `io_in` changes every cycle, checks back-pressure and shows whether the inputs are sampled only at the end of the done cycle.

// File: rtl/rmw_pkg.sv
package rmw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_LOAD    = 3'd1,
    ST_SETTLE  = 3'd2,
    ST_MODIFY  = 3'd3,
    ST_RELEASE = 3'd4
  } rmw_state_e;
endpackage

// File: rtl/rmw_ctrl.sv
module rmw_ctrl
  import rmw_pkg::*;
#(
  parameter int SETTLE = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  output logic req_ready,
  output logic accept,
  output logic mod_exit,
  output logic rel_exit,
  output logic done
);
  rmw_state_e state_q, state_d;
  rmw_state_e after_load;

  generate
    if (SETTLE != 0) begin : g_wait
      assign after_load = ST_SETTLE;
    end else begin : g_direct
      assign after_load = ST_MODIFY;
    end
  endgenerate

  assign req_ready = (state_q == ST_IDLE) || (state_q == ST_RELEASE);
  assign accept    = req_valid && req_ready;
  assign mod_exit  = (state_q == ST_MODIFY);
  assign rel_exit  = (state_q == ST_RELEASE);
  assign done      = rel_exit;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (accept) state_d = ST_LOAD;
      ST_LOAD:    state_d = after_load;
      ST_SETTLE:  state_d = ST_MODIFY;
      ST_MODIFY:  state_d = ST_RELEASE;
      ST_RELEASE: state_d = accept ? ST_LOAD : ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  a_r2_accept_loads: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (state_q == ST_LOAD));
  a_r6_release_after_modify: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RELEASE) |-> ($past(state_q) == ST_MODIFY));
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done || $past(accept)) == 1'b1 ? !done : 1'b1);

  generate
    if (SETTLE != 0) begin : g_chk_wait
      a_r10_wait_before_modify: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MODIFY) |-> ($past(state_q) == ST_SETTLE));
    end else begin : g_chk_direct
      a_r10_no_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MODIFY) |-> ($past(state_q) == ST_LOAD));
    end
  endgenerate
endmodule

// File: rtl/rmw_datapath.sv
module rmw_datapath #(
  parameter int AW  = 8,
  parameter int BAW = 6,
  parameter int DW  = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           accept,
  input  logic           mod_exit,
  input  logic           rel_exit,
  input  logic [AW-1:0]  req_addr,
  input  logic [DW-1:0]  req_mask,
  input  logic [DW-1:0]  rdata_a,
  input  logic [DW-1:0]  rdata_b,
  output logic [AW-1:0]  addr,
  output logic [BAW-1:0] addr_b,
  output logic           we,
  output logic [DW-1:0]  wdata,
  output logic [DW-1:0]  capture_b
);
  logic [DW-1:0] mask_q;

  assign addr_b = addr[BAW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr      <= '0;
      mask_q    <= '0;
      we        <= 1'b0;
      wdata     <= '0;
      capture_b <= '0;
    end else begin
      if (accept) begin
        addr   <= req_addr;
        mask_q <= req_mask;
      end
      if (mod_exit) begin
        wdata     <= rdata_a ^ mask_q;
        capture_b <= rdata_b;
        we        <= 1'b1;
      end else if (rel_exit) begin
        we        <= 1'b0;
      end
    end
  end

  a_r3_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    mod_exit |=> $stable(addr));
  a_r4_we_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> !we);
  a_r4_we_in_release: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> rel_exit);
  a_r8_capture_port_b: assert property (@(posedge clk) disable iff (!rst_n)
    mod_exit |=> (capture_b == $past(rdata_b)));
endmodule

// File: rtl/rmw_io_sampler.sv
module rmw_io_sampler #(
  parameter int IOW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           take,
  input  logic [IOW-1:0] pins,
  output logic [IOW-1:0] held
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    held <= '0;
    else if (take) held <= pins;
  end

  a_r7_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(held));
endmodule

// File: rtl/rmw_sequencer.sv
module rmw_sequencer #(
  parameter int AW     = 8,
  parameter int BAW    = 6,
  parameter int DW     = 16,
  parameter int IOW    = 4,
  parameter int SETTLE = 0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [AW-1:0]  req_addr,
  input  logic [DW-1:0]  req_mask,
  input  logic [IOW-1:0] io_in,
  output logic [AW-1:0]  ram_addr_a,
  output logic [BAW-1:0] ram_addr_b,
  output logic           ram_we,
  output logic [DW-1:0]  ram_wdata,
  input  logic [DW-1:0]  ram_rdata_a,
  input  logic [DW-1:0]  ram_rdata_b,
  output logic           done,
  output logic [IOW-1:0] io_sampled,
  output logic [DW-1:0]  portb_capture
);
  logic accept, mod_exit, rel_exit;

  rmw_ctrl #(.SETTLE(SETTLE)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .accept(accept), .mod_exit(mod_exit), .rel_exit(rel_exit), .done(done)
  );

  rmw_datapath #(.AW(AW), .BAW(BAW), .DW(DW)) u_dp (
    .clk(clk), .rst_n(rst_n), .accept(accept), .mod_exit(mod_exit),
    .rel_exit(rel_exit), .req_addr(req_addr), .req_mask(req_mask),
    .rdata_a(ram_rdata_a), .rdata_b(ram_rdata_b), .addr(ram_addr_a),
    .addr_b(ram_addr_b), .we(ram_we), .wdata(ram_wdata),
    .capture_b(portb_capture)
  );

  rmw_io_sampler #(.IOW(IOW)) u_io (
    .clk(clk), .rst_n(rst_n), .take(rel_exit), .pins(io_in), .held(io_sampled)
  );

  a_r5_slice: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (ram_addr_b == ram_addr_a[BAW-1:0]));
endmodule

// File: tb/tb_rmw_sequencer.sv
module tb_ram_model #(
  parameter int AW = 8, parameter int BAW = 6, parameter int DW = 16
) (
  input  logic           clk,
  input  logic [AW-1:0]  addr_a,
  input  logic           we,
  input  logic [DW-1:0]  wdata,
  output logic [DW-1:0]  rdata_a,
  input  logic [BAW-1:0] addr_b,
  output logic [DW-1:0]  rdata_b
);
  logic [DW-1:0] mem [2**AW];
  initial begin
    for (int i = 0; i < 2**AW; i++) mem[i] = DW'(i * 16'h1357) ^ DW'(16'hA5A5);
    rdata_a = '0;
    rdata_b = '0;
  end
  always @(posedge clk) begin
    rdata_b <= mem[AW'(addr_b)];
    if (we) begin
      mem[addr_a] <= wdata;
      rdata_a     <= wdata;
    end else begin
      rdata_a     <= mem[addr_a];
    end
  end
endmodule

module tb_rmw_sequencer;
  localparam int AW = 8, BAW = 6, DW = 16, IOW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit started = 0, finished = 0;

  logic           v     [2];
  logic [AW-1:0]  a_in  [2];
  logic [DW-1:0]  m_in  [2];
  logic [IOW-1:0] io_in = '0;

  logic           o_rdy [2], o_we [2], o_done [2];
  logic [AW-1:0]  o_addr [2];
  logic [BAW-1:0] o_addrb [2];
  logic [DW-1:0]  o_wd [2], o_rda [2], o_rdb [2], o_cap [2];
  logic [IOW-1:0] o_io [2];

  rmw_sequencer #(.AW(AW), .BAW(BAW), .DW(DW), .IOW(IOW), .SETTLE(0)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(v[0]), .req_ready(o_rdy[0]),
    .req_addr(a_in[0]), .req_mask(m_in[0]), .io_in(io_in),
    .ram_addr_a(o_addr[0]), .ram_addr_b(o_addrb[0]), .ram_we(o_we[0]),
    .ram_wdata(o_wd[0]), .ram_rdata_a(o_rda[0]), .ram_rdata_b(o_rdb[0]),
    .done(o_done[0]), .io_sampled(o_io[0]), .portb_capture(o_cap[0]));

  rmw_sequencer #(.AW(AW), .BAW(BAW), .DW(DW), .IOW(IOW), .SETTLE(1)) dut_settle (
    .clk(clk), .rst_n(rst_n), .req_valid(v[1]), .req_ready(o_rdy[1]),
    .req_addr(a_in[1]), .req_mask(m_in[1]), .io_in(io_in),
    .ram_addr_a(o_addr[1]), .ram_addr_b(o_addrb[1]), .ram_we(o_we[1]),
    .ram_wdata(o_wd[1]), .ram_rdata_a(o_rda[1]), .ram_rdata_b(o_rdb[1]),
    .done(o_done[1]), .io_sampled(o_io[1]), .portb_capture(o_cap[1]));

  tb_ram_model #(.AW(AW), .BAW(BAW), .DW(DW)) ram0 (
    .clk(clk), .addr_a(o_addr[0]), .we(o_we[0]), .wdata(o_wd[0]),
    .rdata_a(o_rda[0]), .addr_b(o_addrb[0]), .rdata_b(o_rdb[0]));
  tb_ram_model #(.AW(AW), .BAW(BAW), .DW(DW)) ram1 (
    .clk(clk), .addr_a(o_addr[1]), .we(o_we[1]), .wdata(o_wd[1]),
    .rdata_a(o_rda[1]), .addr_b(o_addrb[1]), .rdata_b(o_rdb[1]));

  // request queues, one per copy, entry = {addr, mask}
  logic [AW+DW-1:0] q [2][$];
  always @(posedge clk) begin
    for (int k = 0; k < 2; k++) begin
      if (!v[k] || o_rdy[k]) begin
        if (q[k].size() > 0) begin
          v[k]    <= 1'b1;
          a_in[k] <= q[k][0][AW+DW-1:DW];
          m_in[k] <= q[k][0][DW-1:0];
          q[k].pop_front();
        end else begin
          v[k] <= 1'b0;
        end
      end
    end
  end

  // reference model
  int             ph [2];
  logic [AW-1:0]  r_addr [2];
  logic [DW-1:0]  r_mask [2], r_wd [2], r_cap [2];
  logic [IOW-1:0] r_io [2];
  logic [DW-1:0]  mref [2][2**AW];
  int             n_req [2], n_done [2];

  initial begin
    for (int k = 0; k < 2; k++) begin
      v[k] = 0; a_in[k] = '0; m_in[k] = '0;
      ph[k] = 0; r_addr[k] = '0; r_mask[k] = '0; r_wd[k] = '0;
      r_cap[k] = '0; r_io[k] = '0; n_req[k] = 0; n_done[k] = 0;
      for (int i = 0; i < 2**AW; i++) mref[k][i] = DW'(i * 16'h1357) ^ DW'(16'hA5A5);
    end
  end

  always @(posedge clk) begin
    started <= 1'b1;
    for (int k = 0; k < 2; k++) begin
      int last;
      bit acc;
      last = 3 + k;
      if (!rst_n) begin
        ph[k] = 0; r_addr[k] = '0; r_mask[k] = '0; r_wd[k] = '0;
        r_cap[k] = '0; r_io[k] = '0;
      end else begin
        acc = v[k] && (ph[k] == 0 || ph[k] == last);
        if (ph[k] == last - 1) begin
          r_wd[k]  = mref[k][r_addr[k]] ^ r_mask[k];
          r_cap[k] = mref[k][{2'b00, r_addr[k][BAW-1:0]}];
        end
        if (ph[k] == last) begin
          mref[k][r_addr[k]] = r_wd[k];
          r_io[k] = io_in;
        end
        if (acc) begin
          ph[k] = 1; r_addr[k] = a_in[k]; r_mask[k] = m_in[k]; n_req[k]++;
        end else if (ph[k] == last) ph[k] = 0;
        else if (ph[k] > 0) ph[k]++;
      end
    end
  end

  task automatic chk(input string req, input int k, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s copy%0d %s actual=%h expected=%h at %0t", req, k, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started && !finished) begin
      for (int k = 0; k < 2; k++) begin
        int last;
        string lat;
        last = 3 + k;
        lat = (k == 0) ? "R6" : "R10";
        if (o_done[k] === 1'b1) n_done[k]++;
        chk("R2", k, "req_ready", 32'(o_rdy[k]), 32'(ph[k] == 0 || ph[k] == last));
        chk("R3", k, "ram_addr_a", 32'(o_addr[k]), 32'(r_addr[k]));
        chk("R5", k, "ram_addr_b", 32'(o_addrb[k]), 32'(r_addr[k][BAW-1:0]));
        chk("R4", k, "ram_we", 32'(o_we[k]), 32'(ph[k] == last));
        chk(lat, k, "done", 32'(o_done[k]), 32'(ph[k] == last));
        chk("R4", k, "ram_wdata", 32'(o_wd[k]), 32'(r_wd[k]));
        chk("R7", k, "io_sampled", 32'(o_io[k]), 32'(r_io[k]));
        chk("R8", k, "portb_capture", 32'(o_cap[k]), 32'(r_cap[k]));
      end
    end
  end

  always @(negedge clk) io_in <= io_in + IOW'(3);

  task automatic push(input logic [AW-1:0] a, input logic [DW-1:0] m);
    q[0].push_back({a, m});
    q[1].push_back({a, m});
  endtask

  task automatic drain();
    while (q[0].size() > 0 || q[1].size() > 0 || v[0] || v[1] || ph[0] != 0 || ph[1] != 0)
      @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    logic [15:0] lfsr;
    logic [DW-1:0] expect40;
    repeat (3) @(negedge clk);
    for (int k = 0; k < 2; k++) begin
      chk("R1", k, "reset we", 32'(o_we[k]), 0);
      chk("R1", k, "reset done", 32'(o_done[k]), 0);
      chk("R1", k, "reset ready", 32'(o_rdy[k]), 1);
      chk("R1", k, "reset addr", 32'(o_addr[k]), 0);
      chk("R1", k, "reset wdata", 32'(o_wd[k]), 0);
      chk("R1", k, "reset io", 32'(o_io[k]), 0);
      chk("R1", k, "reset capture", 32'(o_cap[k]), 0);
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // single operations with gaps: mixed, zero and all-ones masks
    push(8'h05, 16'h00FF); drain();
    push(8'h11, 16'h0000); drain();
    push(8'hC7, 16'hFFFF); drain();
    // R9: back-to-back on one address with high bits set
    expect40 = DW'(8'h40 * 16'h1357) ^ DW'(16'hA5A5);
    push(8'h40, 16'h1234); push(8'h40, 16'h0F0F); push(8'h40, 16'h8001);
    expect40 = expect40 ^ 16'h1234 ^ 16'h0F0F ^ 16'h8001;
    drain();
    chk("R9", 0, "mem[0x40]", 32'(ram0.mem[8'h40]), 32'(expect40));
    chk("R9", 1, "mem[0x40]", 32'(ram1.mem[8'h40]), 32'(expect40));
    // pseudo-random bursts
    lfsr = 16'hACE1;
    for (int b = 0; b < 6; b++) begin
      for (int i = 0; i < 5; i++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        push(lfsr[7:0], lfsr ^ 16'h5A3C);
      end
      drain();
    end
    for (int k = 0; k < 2; k++)
      chk(k == 0 ? "R6" : "R10", k, "done pulses vs requests", 32'(n_done[k]), 32'(n_req[k]));
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL R6 watchdog expired, actual=hung expected=complete");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule